// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller connects a single synchronous host to a 16K-by-1 dynamic memory. The memory takes its row and column addresses over one shared 7-bit bus. A host request carries a 14-bit address, a read strobe, a write strobe and one write-data bit, and it is taken on a valid/ready handshake. The controller turns each request into strobe sequences on RAS, CAS and WE. A read returns the sampled data-out bit on a one-cycle response pulse. A write alone becomes an early write, with WE already low when CAS falls. Both strobes together become a read-modify-write: the old bit is returned and the new bit is stored in the same CAS window.

After an access the row stays open with RAS low. A later request to the same row is served as a page-mode access that only cycles CAS. A request to another row closes the page first. A free-running timer requests a RAS-only refresh at a fixed interval. A 7-bit row counter supplies the row to refresh, so all 128 rows are visited in turn. A pending refresh wins over host traffic at the next access boundary. Every pulse width, setup and precharge time is a parameter counted in clock cycles.

Top module: `dram_ctrl`

## Requirements
- R1: The host address is split with the row in bits 6:0, which is presented when RAS falls, and the column in bits 13:7, which is presented when CAS falls. A read returns the bit stored at that 14-bit address.
- R2: RAS falls only while CAS is high. CAS falls only while RAS is low, and at least T_RCD clocks after RAS fell.
- R3: A request with the read strobe set (read strobe 1, write strobe 0, or both set) gives exactly one rsp_valid_o pulse. Its data is the data-out bit sampled T_CAC clocks after CAS fell, and the responses come in request order.
- R4: A request with write strobe 1 and read strobe 0 is an early write. WE is low before CAS falls and stays low until CAS rises, and there is no response.
- R5: A request with both strobes set is a read-modify-write. WE is high when CAS falls, and WE falls no earlier than T_CAC clocks after CAS fell. The response holds the old bit, and the cell then holds the new bit.
- R6: Requests that follow one another with the same row are served with RAS held low. Between two CAS pulses, CAS stays high for at least T_CP clocks.
- R7: A request to a different row than the open one makes RAS rise before it is served. RAS stays high for at least T_RP clocks before every fall.
- R8: A refresh is a RAS low pulse of at least T_RAS clocks with CAS high. The refresh rows run 0, 1, 2, … and wrap from 127 to 0. Refreshes recur every REF_INTERVAL clocks within an access length.
- R9: A due refresh takes priority over host requests. Ready stays low while the refresh is pending, and an open page is closed for it, even under a back-to-back stream of requests to the open row.
- R10: During reset RAS, CAS and WE are high (inactive) and rsp_valid_o is low. Ready is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller accepts the request this cycle |
| req_rd_i | input | 1 | Read strobe |
| req_wr_i | input | 1 | Write strobe |
| req_addr_i | input | 14 | Cell address: row in 6:0, column in 13:7 |
| req_wdata_i | input | 1 | Bit to write |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 1 | Read data (old bit for read-modify-write) |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_addr_o | output | 7 | Shared row/column address bus |
| dram_din_o | output | 1 | Data to the memory |
| dram_dout_i | input | 1 | Data from the memory |

## Verification
The case that is hardest to reach is a refresh that becomes due while a page is open and same-row requests keep arriving. The bench drives a long unbroken stream of mixed operations on one row. For the whole stream it checks that the refresh interval still holds and that the rows advance in order. A behavioural memory model on the bench side makes data-out invalid until the access time has passed, so sampling even one clock early returns an unknown value. The model also records whether WE was low at the CAS fall, or fell later inside the CAS window, and matches that against the kind of operation the host sent.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    S_IDLE,  // RAS high, precharge countdown
    S_RSET,  // row address settling
    S_RCD,   // RAS low, waiting RAS-to-CAS
    S_CSET,  // column address settling
    S_CAS,   // CAS low, access time
    S_RMW,   // late WE pulse
    S_CPRE,  // CAS precharge, page open
    S_PAGE,  // page open, waiting
    S_FSET,  // refresh row settling
    S_FRAS   // refresh RAS pulse
  } seq_state_e;
endpackage

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int ROW_W        = 7,
  parameter int REF_INTERVAL = 781
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TMR_W = $clog2(REF_INTERVAL);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= TMR_W'(REF_INTERVAL - 1);
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      if (tmr_q == '0) begin
        tmr_q  <= TMR_W'(REF_INTERVAL - 1);
        pend_o <= 1'b1;
      end else begin
        tmr_q <= tmr_q - 1'b1;
        if (ack_i) pend_o <= 1'b0;
      end
      if (ack_i) row_o <= row_o + 1'b1;
    end
  end

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> row_o == ROW_W'($past(row_o) + 1'b1)); // R8
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o); // R9
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W = 7,
  parameter int COL_W = 7,
  parameter int T_RP  = 5,
  parameter int T_RCD = 2,
  parameter int T_CAC = 3,
  parameter int T_WP  = 3,
  parameter int T_CP  = 3,
  parameter int T_RAS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_rd_i,
  input  logic                   req_wr_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic                   req_wdata_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_rdata_o,
  input  logic                   ref_pend_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  output logic                   ref_ack_o,
  output logic                   ras_no,
  output logic                   cas_no,
  output logic                   we_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_o,
  output logic                   din_o,
  input  logic                   dout_i
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_M1   = (T_RP  > T_RCD) ? T_RP : T_RCD;
  localparam int T_M2   = (T_CAC > T_WP)  ? T_CAC : T_WP;
  localparam int T_M3   = (T_CP  > T_RAS) ? T_CP : T_RAS;
  localparam int T_M12  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX  = (T_M12 > T_M3) ? T_M12 : T_M3;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] open_row_q;
  logic [COL_W-1:0] col_q;
  logic             rd_q, wr_q;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             row_hit, accept, cnt_zero;

  assign req_row  = req_addr_i[ROW_W-1:0];
  assign req_col  = req_addr_i[ADDR_W-1:ROW_W];
  assign row_hit  = (req_row == open_row_q);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    req_ready_o = 1'b0;
    if (!ref_pend_i) begin
      if (state_q == S_IDLE && cnt_zero) req_ready_o = 1'b1;
      if (state_q == S_PAGE && row_hit)  req_ready_o = 1'b1;
    end
  end

  assign accept    = req_valid_i && req_ready_o;
  assign ref_ack_o = (state_q == S_FRAS) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      open_row_q  <= '0;
      col_q       <= '0;
      rd_q        <= 1'b0;
      wr_q        <= 1'b0;
      ras_no      <= 1'b1;
      cas_no      <= 1'b1;
      we_no       <= 1'b1;
      addr_o      <= '0;
      din_o       <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept) begin
        open_row_q <= req_row;
        col_q      <= req_col;
        rd_q       <= req_rd_i;
        wr_q       <= req_wr_i;
        din_o      <= req_wdata_i;
      end
      unique case (state_q)
        S_IDLE: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (ref_pend_i) begin
            addr_o  <= MUX_W'(ref_row_i);
            state_q <= S_FSET;
          end else if (req_valid_i) begin
            addr_o  <= MUX_W'(req_row);
            state_q <= S_RSET;
          end
        end
        S_RSET: begin
          ras_no  <= 1'b0;
          cnt_q   <= CNT_W'(T_RCD - 1);
          state_q <= S_RCD;
        end
        S_RCD: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else begin
            addr_o  <= MUX_W'(col_q);
            we_no   <= ~(wr_q & ~rd_q);  // early write: WE before CAS
            state_q <= S_CSET;
          end
        end
        S_CSET: begin
          cas_no  <= 1'b0;
          cnt_q   <= CNT_W'(T_CAC - 1);
          state_q <= S_CAS;
        end
        S_CAS: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else begin
            if (rd_q) begin
              rsp_valid_o <= 1'b1;
              rsp_rdata_o <= dout_i;
            end
            if (rd_q && wr_q) begin
              we_no   <= 1'b0;
              cnt_q   <= CNT_W'(T_WP - 1);
              state_q <= S_RMW;
            end else begin
              cas_no  <= 1'b1;
              we_no   <= 1'b1;
              cnt_q   <= CNT_W'(T_CP - 1);
              state_q <= S_CPRE;
            end
          end
        end
        S_RMW: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else begin
            cas_no  <= 1'b1;
            we_no   <= 1'b1;
            cnt_q   <= CNT_W'(T_CP - 1);
            state_q <= S_CPRE;
          end
        end
        S_CPRE: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else state_q <= S_PAGE;
        end
        S_PAGE: begin
          if (ref_pend_i || (req_valid_i && !row_hit)) begin
            ras_no  <= 1'b1;
            cnt_q   <= CNT_W'(T_RP - 1);
            state_q <= S_IDLE;
          end else if (req_valid_i) begin
            addr_o  <= MUX_W'(req_col);
            we_no   <= ~(req_wr_i & ~req_rd_i);
            state_q <= S_CSET;
          end
        end
        S_FSET: begin
          ras_no  <= 1'b0;
          cnt_q   <= CNT_W'(T_RAS - 1);
          state_q <= S_FRAS;
        end
        S_FRAS: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else begin
            ras_no  <= 1'b1;
            cnt_q   <= CNT_W'(T_RP - 1);
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // RAS high-time tracker for the precharge check
  logic [CNT_W:0] ras_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ras_hi_q <= '1;
    else if (!ras_no) ras_hi_q <= '0;
    else if (ras_hi_q != '1) ras_hi_q <= ras_hi_q + 1'b1;
  end

  AST_RAS_FALL_CAS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> cas_no); // R2
  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> !ras_no); // R2
  AST_EARLY_WE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_no && $past(!cas_no) && $past(!we_no)) |-> !we_no); // R4
  AST_NO_ACCEPT_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> !ref_pend_i); // R9
  AST_RAS_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> ras_hi_q >= (CNT_W+1)'(T_RP)); // R7
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W        = 7,
  parameter int COL_W        = 7,
  parameter int T_RP         = 5,
  parameter int T_RCD        = 2,
  parameter int T_CAC        = 3,
  parameter int T_WP         = 3,
  parameter int T_CP         = 3,
  parameter int T_RAS        = 8,
  parameter int REF_INTERVAL = 781
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_rd_i,
  input  logic                   req_wr_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic                   req_wdata_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_rdata_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic                   dram_din_o,
  input  logic                   dram_dout_i
);
  logic             ref_pend, ref_ack;
  logic [ROW_W-1:0] ref_row;

  dram_ref_sched #(
    .ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)
  ) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack),
    .pend_o(ref_pend), .row_o(ref_row)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAC(T_CAC), .T_WP(T_WP), .T_CP(T_CP), .T_RAS(T_RAS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_rd_i(req_rd_i), .req_wr_i(req_wr_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .ref_pend_i(ref_pend), .ref_row_i(ref_row), .ref_ack_o(ref_ack),
    .ras_no(dram_ras_no), .cas_no(dram_cas_no), .we_no(dram_we_no),
    .addr_o(dram_addr_o), .din_o(dram_din_o), .dout_i(dram_dout_i)
  );
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int  T_RP = 3, T_RCD = 2, T_CAC = 3, T_WP = 2, T_CP = 2, T_RAS = 4;
  localparam int  REF_INTERVAL = 150;
  localparam int  REF_SLACK = 30;
  localparam time TCK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, rd_s = 1'b0, wr_s = 1'b0, wd = 1'b0;
  logic [13:0] haddr = '0;
  logic ready, rsp_valid, rsp_rdata, ras_n, cas_n, we_n, din, dout;
  logic [6:0] maddr;

  always #10 clk = ~clk;

  dram_ctrl #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAC(T_CAC), .T_WP(T_WP), .T_CP(T_CP),
    .T_RAS(T_RAS), .REF_INTERVAL(REF_INTERVAL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_rd_i(rd_s), .req_wr_i(wr_s), .req_addr_i(haddr), .req_wdata_i(wd),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_addr_o(maddr), .dram_din_o(din), .dram_dout_i(dout)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pat(input int a);
    logic [13:0] v;
    v = a[13:0];
    return ^(v & 14'h2D5B) ^ v[9];
  endfunction

  logic [16383:0] dram_mem, ref_mem;
  logic   exp_q[$];
  string  tag_q[$];
  int     kind_q[$];

  // memory model
  logic [6:0]  m_row = '0, m_col = '0;
  logic [13:0] m_idx = '0;
  time t_ras_fall = 0, t_ras_rise = 0, t_cas_fall = 0, t_cas_rise = 0, t_last_ref = 0;
  bit  ras_low_seen = 0, ras_rose_once = 0, cas_low_seen = 0;
  bit  cas_in_win = 0, cas_rose_in_win = 0, m_we_at_fall = 1, m_rmw = 0;
  int  ref_cnt = 0, ras_rise_cnt = 0;
  logic [6:0]   exp_ref_row = '0;
  logic [127:0] refreshed = '0;
  logic rd_val;
  initial dout = 1'bz;

  always @(negedge ras_n) begin
    if (ras_rose_once) chk(($time - t_ras_rise) / TCK >= T_RP, "R7 RAS precharge",
                           32'(($time - t_ras_rise) / TCK), T_RP);
    chk(cas_n === 1'b1, "R2 CAS high at RAS fall", cas_n, 1);
    m_row = maddr; t_ras_fall = $time; ras_low_seen = 1;
    cas_in_win = 0; cas_rose_in_win = 0;
  end

  always @(posedge ras_n) if (ras_low_seen) begin
    if (!cas_in_win) begin
      chk(m_row === exp_ref_row, "R8 refresh row order", m_row, exp_ref_row);
      chk(($time - t_ras_fall) / TCK >= T_RAS, "R8 refresh pulse width",
          32'(($time - t_ras_fall) / TCK), T_RAS);
      if (ref_cnt > 0)
        chk((t_ras_fall - t_last_ref) / TCK >= REF_INTERVAL - REF_SLACK &&
            (t_ras_fall - t_last_ref) / TCK <= REF_INTERVAL + REF_SLACK,
            "R9 refresh interval", 32'((t_ras_fall - t_last_ref) / TCK), REF_INTERVAL);
      refreshed[m_row] = 1'b1;
      exp_ref_row = exp_ref_row + 1'b1;
      ref_cnt++;
      t_last_ref = t_ras_fall;
    end
    t_ras_rise = $time; ras_rose_once = 1; ras_rise_cnt++;
  end

  always @(negedge cas_n) begin
    chk(ras_n === 1'b0, "R2 RAS low at CAS fall", ras_n, 0);
    chk(($time - t_ras_fall) / TCK >= T_RCD, "R2 RAS-to-CAS",
        32'(($time - t_ras_fall) / TCK), T_RCD);
    if (cas_rose_in_win) chk(($time - t_cas_rise) / TCK >= T_CP, "R6 CAS precharge",
                             32'(($time - t_cas_rise) / TCK), T_CP);
    m_col = maddr; m_idx = {m_col, m_row};
    t_cas_fall = $time; cas_low_seen = 1; cas_in_win = 1;
    m_we_at_fall = we_n; m_rmw = 0;
    if (we_n === 1'b0) begin
      dram_mem[m_idx] = din;
      dout = 1'bz;
    end else begin
      rd_val = dram_mem[m_idx];
      dout = 1'bx;
      #(T_CAC * TCK - 5);
      if (cas_n === 1'b0) dout = rd_val;
    end
  end

  always @(negedge we_n) if (cas_low_seen && cas_n === 1'b0 && ras_n === 1'b0) begin
    chk(($time - t_cas_fall) / TCK >= T_CAC, "R5 late WE after access",
        32'(($time - t_cas_fall) / TCK), T_CAC);
    dram_mem[m_idx] = din;
    m_rmw = 1;
  end

  always @(posedge cas_n) if (cas_low_seen) begin
    int kind, ek;
    dout = 1'bz;
    t_cas_rise = $time; cas_rose_in_win = 1;
    kind = (m_we_at_fall === 1'b0) ? 1 : (m_rmw ? 2 : 0);
    if (kind_q.size() == 0) chk(0, "R4 unexpected CAS cycle", kind, 99);
    else begin
      ek = kind_q.pop_front();
      chk(kind == ek, (ek == 2) ? "R5 cycle kind" : "R4 cycle kind", kind, ek);
    end
  end

  always @(negedge clk) if (rst_n && rsp_valid) begin
    logic e; string t;
    if (exp_q.size() == 0) chk(0, "R3 unexpected response", rsp_rdata, 0);
    else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(rsp_rdata === e, t, rsp_rdata, e);
    end
  end

  task automatic host(input bit rd, input bit wr, input logic [13:0] a, input logic d, input string tag);
    @(negedge clk);
    valid = 1'b1; rd_s = rd; wr_s = wr; haddr = a; wd = d;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (rd) begin exp_q.push_back(ref_mem[a]); tag_q.push_back(tag); end
    if (wr) ref_mem[a] = d;
    kind_q.push_back((rd && wr) ? 2 : (wr ? 1 : 0));
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int c0;
    time tb;
    logic [6:0] prow;
    void'($urandom(32'd41));
    for (int k = 0; k < 16384; k++) begin dram_mem[k] = pat(k); ref_mem[k] = pat(k); end
    repeat (3) @(negedge clk);
    chk(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R10 strobes idle in reset",
        {ras_n, cas_n, we_n}, 3'b111);
    chk(rsp_valid === 1'b0, "R10 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R10 ready after reset", ready, 1);

    // R1 address split and boundaries
    host(1, 0, 14'h0000, 0, "R1 read 0000");
    host(1, 0, 14'h3FFF, 0, "R1 read 3FFF");
    host(1, 0, 14'h0080, 0, "R1 read col1 row0");
    host(1, 0, 14'h0001, 0, "R1 read col0 row1");
    host(1, 0, 14'h1F55, 0, "R3 read");
    // R4 early write then read back
    host(0, 1, 14'h0123, ~pat(14'h0123), "");
    host(1, 0, 14'h0123, 0, "R4 readback");
    // R5 read-modify-write
    host(1, 1, 14'h2A0F, ~pat(14'h2A0F), "R5 old bit");
    host(1, 0, 14'h2A0F, 0, "R5 new bit");
    host(1, 1, 14'h2A0F, pat(14'h2A0F), "R5 old bit again");

    // R6 page burst right after a refresh
    c0 = ref_cnt;
    while (ref_cnt == c0) @(negedge clk);
    host(1, 0, {7'd3, 7'd44}, 0, "R6 page open");
    c0 = ras_rise_cnt;
    host(1, 0, {7'd9, 7'd44}, 0, "R6 page read");
    host(0, 1, {7'd10, 7'd44}, 1, "");
    host(1, 1, {7'd11, 7'd44}, 0, "R6 page rmw");
    host(1, 0, {7'd10, 7'd44}, 0, "R6 page readback");
    chk(ras_rise_cnt == c0, "R6 RAS held across page", ras_rise_cnt, c0);
    host(1, 0, {7'd10, 7'd45}, 0, "R7 miss read");
    chk(ras_rise_cnt == c0 + 1, "R7 row miss closes page", ras_rise_cnt, c0 + 1);

    // R9 sustained same-row stream across several refreshes
    c0 = ref_cnt; tb = $time;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [13:0] a;
      op = $urandom_range(0, 3);
      a = {7'($urandom), 7'd5};
      case (op)
        0, 3: host(1, 0, a, 0, "R9 stream read");
        1: host(0, 1, a, 1'($urandom), "");
        default: host(1, 1, a, 1'($urandom), "R9 stream rmw");
      endcase
    end
    chk(ref_cnt - c0 >= int'(($time - tb) / TCK) / REF_INTERVAL - 1, "R9 refreshes during stream",
        ref_cnt - c0, int'(($time - tb) / TCK) / REF_INTERVAL);

    // random mix with row reuse
    prow = 7'd0;
    for (int i = 0; i < 500; i++) begin
      int op;
      logic [6:0] row;
      logic [13:0] a;
      op = $urandom_range(0, 3);
      row = ($urandom_range(0, 1) == 1) ? prow : 7'($urandom);
      a = {7'($urandom), row};
      prow = row;
      case (op)
        0, 3: host(1, 0, a, 0, "R1 random read");
        1: host(0, 1, a, 1'($urandom), "");
        default: host(1, 1, a, 1'($urandom), "R5 random rmw");
      endcase
    end

    // R8 wait for full refresh coverage and wrap
    for (int i = 0; i < 140 * REF_INTERVAL && ref_cnt < 140; i++) @(negedge clk);
    chk(refreshed === '1, "R8 all rows refreshed", $countones(refreshed), 128);
    chk(ref_cnt >= 129, "R8 refresh counter wrapped", ref_cnt, 129);
    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all responses returned", exp_q.size(), 0);
    chk(kind_q.size() == 0, "R4 all cycles issued", kind_q.size(), 0);
    summary();
    $finish;
  end
endmodule